// File: doc/BRIEF.md
# Iterative Half-Adder Feedback Adder

This block adds two unsigned 16-bit operands using only a row of half adders and a feedback path, with no carry-propagate chain. When a request is accepted, every bit position half-adds its two operand bits. On each later clock, a two-input selector in front of every cell switches to the feedback path. Each cell then half-adds its own previous sum bit with the carry that the cell below produced on the previous clock. The loop ends once no cell holds a carry. At that point the sum is final and completion is signalled.

The time to finish depends on the operands. Operands whose bits never overlap finish after one iteration. The longest ripple, such as all-ones plus one, takes seventeen iterations. The carry out of the top operand bit is kept as a 17th result bit. A request that arrives while an addition is in progress is dropped. The finished result and the completion flag hold until the next request is accepted.

Top module: `hafb_adder`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 0.
- R2: A `req` sampled high at a rising edge while `busy` is 0 is accepted. From the next cycle `busy` is 1 and `done` is 0, until the addition finishes.
- R3: When `done` is 1, `result` equals `a + b` of the accepted request as a 17-bit unsigned value. Bit 16 is the carry out of bit 15.
- R4: Count the iterations of an accepted request as k. The first iteration is the operand half-add, and each later one is a feedback step taken while some carry is non-zero. Then `done` rises and `busy` falls at the k-th rising edge after the accepting edge. That is the edge after the one at which all carries became zero.
- R5: Operands with no common set bit (`a & b == 0`) finish with k = 1, so `done` is seen in the second cycle after acceptance.
- R6: No request needs more than 17 iterations. 0xFFFF + 0x0001 takes exactly 17.
- R7: A `req` while `busy` is 1 is ignored. The running addition keeps its result and its timing, and the new operands are not used.
- R8: While `busy` is 0 and no request is accepted, `result` and `done` hold their values whatever `a` and `b` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start an addition with the present `a` and `b` |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| busy | output | 1 | Addition in progress; feedback selected |
| done | output | 1 | Last addition finished; held until next accept |
| result | output | 17 | Sum with carry out in bit 16 |

## Verification
The assertions assume that `a` and `b` are only relevant at the accepting edge. They also assume that `req` may be high for any number of cycles, including while busy. The assertion on a stable idle result assumes `req` is low in the cycles it covers. The stimulus changes operands at will while idle or busy, and deliberately raises `req` during a running addition. It always sets inputs at the falling edge, so every rising edge sees settled values. The patterns include overlap-free operands, the longest ripple, full overflow and pseudo-random pairs.

// File: rtl/hafb_pkg.sv
package hafb_pkg;

    localparam int unsigned HAFB_W = 16;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } hafb_state_e;

    typedef struct packed {
        logic carry;
        logic sum;
    } hafb_pair_t;

    function automatic hafb_pair_t half_add(input logic x, input logic y);
        hafb_pair_t r;
        r.carry = x & y;
        r.sum   = x ^ y;
        return r;
    endfunction

endpackage

// File: rtl/hafb_cell.sv
module hafb_cell
    import hafb_pkg::*;
(
    input  logic       sel_fb,
    input  logic       op_x,
    input  logic       op_y,
    input  logic       prev_sum,
    input  logic       carry_below,
    output hafb_pair_t res
);
    logic in_x;
    logic in_y;

    always_comb begin
        if (sel_fb) begin
            in_x = prev_sum;
            in_y = carry_below;
        end else begin
            in_x = op_x;
            in_y = op_y;
        end
        res = half_add(in_x, in_y);
    end
endmodule

// File: rtl/hafb_ctrl.sv
module hafb_ctrl
    import hafb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic carries_zero,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    hafb_state_e state_q;

    assign busy = (state_q == ST_RUN);
    assign load = req & ~busy;
    assign step = busy & ~carries_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        state_q <= ST_RUN;
                        done    <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (carries_zero) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R7
    busy_req_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && req && !carries_zero) |=> (busy && !done));

    // R4
    finish_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && req) |=> (busy && !done));
endmodule

// File: rtl/hafb_adder.sv
module hafb_adder
    import hafb_pkg::*;
#(
    parameter int unsigned W = HAFB_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         done,
    output logic [W:0]   result
);
    localparam int unsigned LW    = W + 1;
    localparam int unsigned MAXIT = W + 1;
    localparam int unsigned CW    = $clog2(MAXIT + 2);

    logic [LW-1:0] s_q;
    logic [LW-1:0] c_q;
    logic [LW-1:0] s_nx;
    logic [LW-1:0] c_nx;
    logic          load;
    logic          step;
    logic          carries_zero;

    assign carries_zero = ~|c_q;

    for (genvar i = 0; i < LW; i++) begin : g_lane
        hafb_pair_t pr;
        logic       ox;
        logic       oy;
        logic       cb;
        if (i < W) begin : g_op
            assign ox = a[i];
            assign oy = b[i];
        end else begin : g_top
            assign ox = 1'b0;
            assign oy = 1'b0;
        end
        if (i == 0) begin : g_lsb
            assign cb = 1'b0;
        end else begin : g_up
            assign cb = c_q[i-1];
        end
        hafb_cell u_cell (
            .sel_fb      (busy),
            .op_x        (ox),
            .op_y        (oy),
            .prev_sum    (s_q[i]),
            .carry_below (cb),
            .res         (pr)
        );
        assign s_nx[i] = pr.sum;
        assign c_nx[i] = pr.carry;
    end

    hafb_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .carries_zero (carries_zero),
        .load         (load),
        .step         (step),
        .busy         (busy),
        .done         (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
            c_q <= '0;
        end else if (load || step) begin
            s_q <= s_nx;
            c_q <= c_nx;
        end
    end

    assign result = s_q;

    logic [CW-1:0] iter_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            iter_q <= '0;
        end else if (load) begin
            iter_q <= CW'(1);
        end else if (step) begin
            iter_q <= iter_q + CW'(1);
        end
    end

    // R3
    pair_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q & c_q) == '0);

    // R3
    top_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
        !c_q[LW-1]);

    // R4
    done_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> carries_zero);

    // R6
    iter_bound_chk: assert property (@(posedge clk) disable iff (rst)
        iter_q <= CW'(MAXIT));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req) |=> ($stable(result) && $stable(done)));
endmodule

// File: tb/hafb_adder_test.sv
module hafb_adder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        busy;
    logic        done;
    logic [16:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string cur = "R1";

    always #2 clk = ~clk;

    hafb_adder uut (
        .clk(clk), .rst(rst), .req(req), .a(a), .b(b),
        .busy(busy), .done(done), .result(result)
    );

    // behavioural reference model
    bit        m_busy = 0;
    bit        m_done = 0;
    int        m_res  = 0;
    int        m_fin  = 0;
    int        m_rem  = 0;
    int        m_k    = 0;

    function automatic int iter_count(input int x, input int y);
        int s = x ^ y;
        int c = x & y;
        int k = 1;
        int t;
        while (c != 0) begin
            t = s;
            s = s ^ (c << 1);
            c = t & (c << 1);
            k++;
        end
        return k;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_res = 0; m_rem = 0;
        end else if (m_busy) begin
            if (m_rem > 0) m_rem--;
            else begin
                m_busy = 0; m_done = 1; m_res = m_fin;
            end
        end else if (req) begin
            m_k    = iter_count(int'(a), int'(b));
            m_fin  = int'(a) + int'(b);
            m_rem  = m_k - 1;
            m_busy = 1;
            m_done = 0;
        end
    end

    task automatic chk(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", cur, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("busy", int'(busy), int'(m_busy));
            chk("done", int'(done), int'(m_done));
            if (!m_busy) chk("result", int'(result), m_res);
        end
    end

    task automatic run_op(input logic [15:0] x, input logic [15:0] y,
                          input int exp_lat, input string tag);
        int n = 0;
        cur = tag;
        @(negedge clk);
        req = 1'b1; a = x; b = y;
        forever begin
            @(negedge clk);
            req = 1'b0;
            a = ~x; b = y ^ 16'h5A5A;
            n++;
            if (done || n > 40) break;
        end
        if (exp_lat > 0) chk("latency", n, exp_lat);
        chk("sum", int'(result), int'(x) + int'(y));
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        cur = "R1";
        chk("busy", int'(busy), 0);
        chk("done", int'(done), 0);
        chk("result", int'(result), 0);

        // R2 accept then busy
        cur = "R2";
        @(negedge clk);
        req = 1'b1; a = 16'h1234; b = 16'h4321;
        @(negedge clk);
        req = 1'b0;
        chk("busy", int'(busy), 1);
        chk("done", int'(done), 0);
        while (!done) @(negedge clk);
        cur = "R3";
        chk("sum", int'(result), 32'h5555);

        // R5 no overlapping bits
        run_op(16'h00F0, 16'h0F0F, 2, "R5");
        run_op(16'hAAAA, 16'h5555, 2, "R5");
        run_op(16'h0000, 16'h0000, 2, "R5");
        // R6 longest ripple
        run_op(16'hFFFF, 16'h0001, 18, "R6");
        // R3 overflow into bit 16
        run_op(16'hFFFF, 16'hFFFF, 0, "R3");
        run_op(16'h8000, 16'h8000, 0, "R3");
        // R4 data dependent latency
        run_op(16'h0001, 16'h0001, 3, "R4");
        run_op(16'h0003, 16'h0001, 4, "R4");

        lf = 16'hACE1;
        for (int i = 0; i < 24; i++) begin
            logic [15:0] p;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            p = lf;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            run_op(p, lf, iter_count(int'(p), int'(lf)) + 1, "R3");
        end

        // R7 request while busy ignored
        cur = "R7";
        @(negedge clk);
        req = 1'b1; a = 16'hFFFF; b = 16'h0001;
        @(negedge clk);
        a = 16'h0101; b = 16'h0202;
        begin
            int n = 1;
            repeat (3) @(negedge clk);
            n += 3;
            req = 1'b0;
            while (!done && n < 40) begin
                @(negedge clk);
                n++;
            end
            chk("latency", n, 18);
            chk("sum", int'(result), 32'h10000);
        end

        // R8 idle hold
        cur = "R8";
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            a = 16'(i * 16'h1111); b = ~a;
            chk("done", int'(done), 1);
            chk("result", int'(result), 32'h10000);
        end

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule